// File: doc/BRIEF.md
# Accumulator Stored-Program Core

This block is a very small stored-program processor. It holds a 32-word by 32-bit store, a signed accumulator, a program counter and an instruction register. Each instruction names one store word by its 5-bit address and carries a 3-bit function code. The function code selects one of these operations: an indirect absolute jump, an indirect relative jump, a negated load, a store, a subtract, a skip-if-negative, or a halt. Execution runs as a loop. Each pass increments the program counter, fetches the word at the new address, and then executes it. As a result, a jump resumes one word past the value it loads.

Before a run, the store is loaded through a debug request/response port, and results are read back through the same port once the core stops. The request channel uses valid/ready. A request is taken on a clock edge where both `dbg_req_valid` and `dbg_req_ready` are high. `dbg_req_ready` is low while the core is running and while a read response is still waiting, so a requester must hold its request stable until it is taken. The response channel is also valid/ready. The data stays registered and stable until `dbg_rsp_ready` takes it. Writes produce no response.

Top module: `acc_core`

## Requirements
- R1: After reset `halted` is 0, `dbg_req_ready` is 1 and `dbg_rsp_valid` is 0. The program counter and accumulator are 0, so the first instruction after a start comes from address 1, and a halt there is seen 2 cycles after the start pulse is taken.
- R2: Each instruction takes two cycles: fetch, then execute. The fetch adds 1 to the program counter modulo 32 before reading, so execution flows from address 31 to address 0.
- R3: Function code 0 (instruction bits 15:13 = 000, operand address in bits 4:0) loads the program counter with bits 4:0 of the addressed word. The next instruction comes from that value plus 1.
- R4: Function code 1 (001) adds the addressed word to the program counter, modulo 32.
- R5: Function code 2 (010) loads the accumulator with the two's-complement negation of the addressed word.
- R6: Function code 3 (011) writes the accumulator into the addressed word.
- R7: Function code 4 (100) subtracts the addressed word from the accumulator. Code 5 (101) does exactly the same.
- R8: Function code 6 (110) adds 1 to the program counter only when accumulator bit 31 is set. When that bit is clear, the code has no effect.
- R9: Function code 7 (111) stops the core and raises `halted`. `halted` stays high until a start pulse or a reset. A start resumes at the word after the halt, with the accumulator kept.
- R10: A debug write changes the addressed word. A debug read returns the word on the response channel, where it is held stable until taken. No request is accepted while the core runs or while a response is pending.
- R11: A start pulse while the core is running is ignored and does not change the instruction sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume execution when idle |
| halted | output | 1 | Set by a halt instruction |
| dbg_req_valid | input | 1 | Debug request present |
| dbg_req_ready | output | 1 | Debug request can be taken |
| dbg_req_write | input | 1 | 1 = write, 0 = read |
| dbg_req_addr | input | 5 | Store word address |
| dbg_req_wdata | input | 32 | Write data |
| dbg_rsp_valid | output | 1 | Read data present |
| dbg_rsp_ready | input | 1 | Read data taken |
| dbg_rsp_data | output | 32 | Read data |

## Verification
The start pulse is registered, so the first fetch happens one edge after it is taken. Every instruction then costs exactly two edges, and a halt after k instructions is due 2k cycles after the start pulse is lowered. The bench counts falling edges from that point and compares the count with 2k. This cycle count is how it shows that a skip, jump or wrap took the intended path. Store effects are read back through the debug port only after `halted` rises. A read response appears on the falling edge after its request is taken, and it is checked to hold for several cycles while `dbg_rsp_ready` stays low.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_LSB = 13;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_JABS    = 3'd0,
    OP_JREL    = 3'd1,
    OP_LDNEG   = 3'd2,
    OP_STORE   = 3'd3,
    OP_SUB     = 3'd4,
    OP_SUBALT  = 3'd5,
    OP_SKIPNEG = 3'd6,
    OP_HALT    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

endpackage

// File: rtl/acc_store.sv
module acc_store #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int N_RD   = 3
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [N_RD-1:0][ADDR_W-1:0]   raddr,
  output logic [N_RD-1:0][DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata[g] = words[raddr[g]];
  end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_nxt,
  output logic [DATA_W-1:0] acc_nxt,
  output logic              mem_we,
  output logic              halt_req
);
  always_comb begin
    pc_nxt   = pc;
    acc_nxt  = acc;
    mem_we   = 1'b0;
    halt_req = 1'b0;
    unique case (op)
      OP_JABS:    pc_nxt  = operand[ADDR_W-1:0];
      OP_JREL:    pc_nxt  = pc + operand[ADDR_W-1:0];
      OP_LDNEG:   acc_nxt = -operand;
      OP_STORE:   mem_we  = 1'b1;
      OP_SUB,
      OP_SUBALT:  acc_nxt = acc - operand;
      OP_SKIPNEG: if (acc[DATA_W-1]) pc_nxt = pc + 1'b1;
      OP_HALT:    halt_req = 1'b1;
      default:    halt_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] fetch_word,
  input  logic [ADDR_W-1:0] pc_nxt,
  input  logic [DATA_W-1:0] acc_nxt,
  input  logic              halt_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output op_e               ir_op,
  output logic [ADDR_W-1:0] ir_addr,
  output logic              exec_phase,
  output logic              running,
  output logic              halted
);
  phase_e            phase;
  logic [DATA_W-1:0] ir;
  logic              unused_ir_bits;

  assign fetch_addr = pc + 1'b1;
  assign ir_op      = op_e'(ir[OP_LSB +: OP_W]);
  assign ir_addr    = ir[ADDR_W-1:0];
  assign exec_phase = (phase == PH_EXEC);
  assign running    = (phase != PH_IDLE);
  assign unused_ir_bits = ^{ir[DATA_W-1:OP_LSB+OP_W], ir[OP_LSB-1:ADDR_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      pc     <= '0;
      acc    <= '0;
      ir     <= '0;
      halted <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_FETCH;
            halted <= 1'b0;
          end
        end
        PH_FETCH: begin
          pc    <= fetch_addr;
          ir    <= fetch_word;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          pc  <= pc_nxt;
          acc <= acc_nxt;
          if (halt_req) begin
            phase  <= PH_IDLE;
            halted <= 1'b1;
          end else begin
            phase <= PH_FETCH;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: the fetch step advances the program counter by one, modulo the range
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R8: a skip with a non-negative accumulator leaves the counter alone
  p_skip_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && ir_op == OP_SKIPNEG && !acc[DATA_W-1]) |=> (pc == $past(pc)));

  // R9: executing the halt code stops the core and flags it
  p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && ir_op == OP_HALT) |=> (halted && !running));

  // R9: the flag holds until a start pulse
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted);
endmodule

// File: rtl/acc_dbg_port.sv
module acc_dbg_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic take;

  assign req_ready = !busy && !rsp_valid;
  assign take      = req_valid && req_ready;
  assign mem_we    = take && req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem_rdata;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: an unread response stays valid with unchanged data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              halted,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic              dbg_req_write,
  input  logic [ADDR_W-1:0] dbg_req_addr,
  input  logic [DATA_W-1:0] dbg_req_wdata,
  output logic              dbg_rsp_valid,
  input  logic              dbg_rsp_ready,
  output logic [DATA_W-1:0] dbg_rsp_data
);
  localparam int N_RD   = 3;
  localparam int RD_FET = 0;
  localparam int RD_OPN = 1;
  localparam int RD_DBG = 2;

  logic [N_RD-1:0][ADDR_W-1:0] rd_addr;
  logic [N_RD-1:0][DATA_W-1:0] rd_data;
  logic                        st_we;
  logic [ADDR_W-1:0]           st_waddr;
  logic [DATA_W-1:0]           st_wdata;

  logic [ADDR_W-1:0] fetch_addr, pc, pc_nxt, ir_addr;
  logic [DATA_W-1:0] acc, acc_nxt;
  op_e               ir_op;
  logic              exec_phase, running, halt_req, ex_we, core_we;

  logic              dbg_we;
  logic [ADDR_W-1:0] dbg_addr;
  logic [DATA_W-1:0] dbg_wdata;

  assign core_we            = exec_phase && ex_we;
  assign rd_addr[RD_FET]    = fetch_addr;
  assign rd_addr[RD_OPN]    = ir_addr;
  assign rd_addr[RD_DBG]    = dbg_addr;
  assign st_we              = core_we || dbg_we;
  assign st_waddr           = core_we ? ir_addr : dbg_addr;
  assign st_wdata           = core_we ? acc     : dbg_wdata;

  acc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RD(N_RD)) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  acc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fetch_word (rd_data[RD_FET]),
    .pc_nxt     (pc_nxt),
    .acc_nxt    (acc_nxt),
    .halt_req   (halt_req),
    .fetch_addr (fetch_addr),
    .pc         (pc),
    .acc        (acc),
    .ir_op      (ir_op),
    .ir_addr    (ir_addr),
    .exec_phase (exec_phase),
    .running    (running),
    .halted     (halted)
  );

  acc_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
    .op       (ir_op),
    .operand  (rd_data[RD_OPN]),
    .acc      (acc),
    .pc       (pc),
    .pc_nxt   (pc_nxt),
    .acc_nxt  (acc_nxt),
    .mem_we   (ex_we),
    .halt_req (halt_req)
  );

  acc_dbg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dbg (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (running),
    .req_valid (dbg_req_valid),
    .req_ready (dbg_req_ready),
    .req_write (dbg_req_write),
    .req_addr  (dbg_req_addr),
    .req_wdata (dbg_req_wdata),
    .rsp_valid (dbg_rsp_valid),
    .rsp_ready (dbg_rsp_ready),
    .rsp_data  (dbg_rsp_data),
    .mem_we    (dbg_we),
    .mem_addr  (dbg_addr),
    .mem_wdata (dbg_wdata),
    .mem_rdata (rd_data[RD_DBG])
  );

  // R10: the debug side is locked out whenever the sequencer runs
  p_dbg_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !dbg_req_ready);

  // R6: only the store code writes from the core side, never alongside debug
  p_core_write_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> (ir_op == OP_STORE && !dbg_we));
endmodule

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        halted;
  logic        dbg_req_valid = 1'b0;
  logic        dbg_req_ready;
  logic        dbg_req_write = 1'b0;
  logic [4:0]  dbg_req_addr = '0;
  logic [31:0] dbg_req_wdata = '0;
  logic        dbg_rsp_valid;
  logic        dbg_rsp_ready = 1'b0;
  logic [31:0] dbg_rsp_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
    .dbg_req_write(dbg_req_write), .dbg_req_addr(dbg_req_addr),
    .dbg_req_wdata(dbg_req_wdata), .dbg_rsp_valid(dbg_rsp_valid),
    .dbg_rsp_ready(dbg_rsp_ready), .dbg_rsp_data(dbg_rsp_data)
  );

  function automatic logic [31:0] ins(input logic [2:0] op, input logic [4:0] a);
    return {16'h0000, op, 8'h00, a};
  endfunction

  localparam logic [2:0] C_JABS = 3'd0, C_JREL = 3'd1, C_LDN = 3'd2, C_STO = 3'd3,
                         C_SUB = 3'd4, C_SUB5 = 3'd5, C_SKN = 3'd6, C_HLT = 3'd7;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic dbg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = 1'b1; dbg_req_addr = a; dbg_req_wdata = d;
    while (!dbg_req_ready) @(negedge clk);
    @(negedge clk);
    dbg_req_valid = 1'b0; dbg_req_write = 1'b0;
  endtask

  task automatic dbg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = 1'b0; dbg_req_addr = a; dbg_rsp_ready = 1'b1;
    while (!dbg_req_ready) @(negedge clk);
    @(negedge clk);
    dbg_req_valid = 1'b0;
    d = dbg_rsp_valid ? dbg_rsp_data : 32'hBAD0_BAD0;
    @(negedge clk);
    dbg_rsp_ready = 1'b0;
  endtask

  task automatic fill_halt();
    for (int i = 0; i < 32; i++) dbg_write(5'(i), ins(C_HLT, 5'd0));
  endtask

  task automatic expect_word(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    dbg_read(a, d);
    check(d == exp, req, d, exp);
  endtask

  // start pulse, then count falling edges until halted; optionally poke start mid-run
  task automatic run_prog(input int exp_n, input string req, input bit poke);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(halted == 1'b0, {req, " halted cleared by start"}, 32'(halted), 32'd0);
    n = 0;
    while (!halted && n < 400) begin
      @(negedge clk); n++;
      if (n == 3) check(dbg_req_ready == 1'b0, "R10 request blocked while running",
                        32'(dbg_req_ready), 32'd0);
      if (poke && n == 4) start = 1'b1;
      if (poke && n == 5) start = 1'b0;
    end
    check(n == exp_n, {req, " cycles to halt"}, 32'(n), 32'(exp_n));
  endtask

  task automatic t_reset();
    do_reset();
    check(halted == 1'b0, "R1 halted after reset", 32'(halted), 32'd0);
    check(dbg_req_ready == 1'b1, "R1 ready after reset", 32'(dbg_req_ready), 32'd1);
    check(dbg_rsp_valid == 1'b0, "R1 no response after reset", 32'(dbg_rsp_valid), 32'd0);
  endtask

  task automatic t_first_word();
    fill_halt();
    dbg_write(5'd0, ins(C_STO, 5'd21));
    dbg_write(5'd21, 32'h1234_5678);
    do_reset();
    run_prog(2, "R1 first instruction from address 1", 1'b0);
    expect_word(5'd21, 32'h1234_5678, "R1 address 0 not executed");
  endtask

  task automatic t_ldn_sto();
    fill_halt();
    dbg_write(5'd1, ins(C_LDN, 5'd20));
    dbg_write(5'd2, ins(C_STO, 5'd21));
    dbg_write(5'd20, 32'd5);
    do_reset();
    run_prog(6, "R5 R6 load negated then store", 1'b0);
    expect_word(5'd21, 32'hFFFF_FFFB, "R5 R6 stored negation");
  endtask

  task automatic t_sub();
    fill_halt();
    dbg_write(5'd1, ins(C_LDN, 5'd20));
    dbg_write(5'd2, ins(C_SUB, 5'd22));
    dbg_write(5'd3, ins(C_SUB5, 5'd22));
    dbg_write(5'd4, ins(C_STO, 5'd21));
    dbg_write(5'd20, 32'hFFFF_FFF6);
    dbg_write(5'd22, 32'd3);
    do_reset();
    run_prog(10, "R7 subtract sequence", 1'b0);
    expect_word(5'd21, 32'd4, "R7 codes 100 and 101 both subtract");
  endtask

  task automatic t_skip();
    fill_halt();
    dbg_write(5'd1, ins(C_LDN, 5'd20));
    dbg_write(5'd2, ins(C_SKN, 5'd0));
    dbg_write(5'd4, ins(C_STO, 5'd21));
    dbg_write(5'd20, 32'd1);
    dbg_write(5'd21, 32'hDEAD_0001);
    do_reset();
    run_prog(8, "R8 negative accumulator skips", 1'b0);
    expect_word(5'd21, 32'hFFFF_FFFF, "R8 skip landed on address 4");

    fill_halt();
    dbg_write(5'd1, ins(C_LDN, 5'd20));
    dbg_write(5'd2, ins(C_SKN, 5'd0));
    dbg_write(5'd3, ins(C_STO, 5'd21));
    dbg_write(5'd20, 32'd0);
    dbg_write(5'd21, 32'hDEAD_0002);
    do_reset();
    run_prog(8, "R8 zero accumulator no skip", 1'b0);
    expect_word(5'd21, 32'd0, "R8 no skip executed address 3");
  endtask

  task automatic t_jabs();
    fill_halt();
    dbg_write(5'd1, ins(C_JABS, 5'd25));
    dbg_write(5'd10, ins(C_LDN, 5'd26));
    dbg_write(5'd11, ins(C_STO, 5'd27));
    dbg_write(5'd25, 32'hFFFF_FFE9);
    dbg_write(5'd26, 32'd7);
    dbg_write(5'd27, 32'hDEAD_0003);
    do_reset();
    run_prog(8, "R3 absolute jump path", 1'b0);
    expect_word(5'd27, 32'hFFFF_FFF9, "R3 resumed at target plus one");
  endtask

  task automatic t_jrel();
    fill_halt();
    dbg_write(5'd1, ins(C_JREL, 5'd25));
    dbg_write(5'd8, ins(C_LDN, 5'd26));
    dbg_write(5'd9, ins(C_STO, 5'd27));
    dbg_write(5'd25, 32'd6);
    dbg_write(5'd26, 32'd7);
    dbg_write(5'd27, 32'hDEAD_0004);
    do_reset();
    run_prog(8, "R4 relative jump path", 1'b0);
    expect_word(5'd27, 32'hFFFF_FFF9, "R4 relative target reached");
  endtask

  task automatic t_wrap_resume();
    fill_halt();
    dbg_write(5'd1, ins(C_JREL, 5'd25));
    dbg_write(5'd30, ins(C_LDN, 5'd26));
    dbg_write(5'd31, ins(C_STO, 5'd27));
    dbg_write(5'd25, 32'd28);
    dbg_write(5'd26, 32'd3);
    do_reset();
    run_prog(8, "R2 wrap from 31 to 0", 1'b0);
    expect_word(5'd27, 32'hFFFF_FFFD, "R2 words 30 and 31 executed");
    repeat (5) @(negedge clk);
    check(halted == 1'b1, "R9 halted held while idle", 32'(halted), 32'd1);
    dbg_write(5'd26, 32'd4);
    run_prog(8, "R9 resume after halt at address 0", 1'b0);
    expect_word(5'd27, 32'hFFFF_FFFC, "R9 resumed run stored new value");
  endtask

  task automatic t_start_ignored();
    fill_halt();
    for (int i = 1; i <= 10; i++) dbg_write(5'(i), ins(C_SKN, 5'd0));
    do_reset();
    run_prog(22, "R11 start during run ignored", 1'b1);
  endtask

  task automatic t_rsp_hold();
    logic [31:0] first;
    dbg_write(5'd12, 32'hA5A5_0F0F);
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = 1'b0; dbg_req_addr = 5'd12; dbg_rsp_ready = 1'b0;
    while (!dbg_req_ready) @(negedge clk);
    @(negedge clk);
    dbg_req_valid = 1'b0;
    first = dbg_rsp_data;
    check(dbg_rsp_valid && first == 32'hA5A5_0F0F, "R10 read data returned",
          first, 32'hA5A5_0F0F);
    dbg_req_addr = 5'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(dbg_rsp_valid && dbg_rsp_data == first, "R10 response held",
            dbg_rsp_data, first);
      check(dbg_req_ready == 1'b0, "R10 request blocked while response pending",
            32'(dbg_req_ready), 32'd0);
    end
    dbg_rsp_ready = 1'b1;
    @(negedge clk);
    dbg_rsp_ready = 1'b0;
    check(dbg_rsp_valid == 1'b0, "R10 response consumed", 32'(dbg_rsp_valid), 32'd0);
    check(dbg_req_ready == 1'b1, "R10 ready restored", 32'(dbg_req_ready), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=running expected=halted");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_word();
    t_ldn_sto();
    t_sub();
    t_skip();
    t_jabs();
    t_jrel();
    t_wrap_resume();
    t_start_ignored();
    t_rsp_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule